// File: doc/BRIEF.md
# Byte-Lane Asynchronous DRAM Cycle Sequencer

This block sits between a synchronous host and an asynchronous 16-bit DRAM that has one column strobe for each byte. The host issues one word per request over a valid/ready handshake. Each request carries a 22-bit word address, a write flag, two byte enables, write data and a late-write select. The sequencer turns every request into one complete row/column strobe cycle. Each strobe edge sits a fixed number of clocks from the previous one, and every such count is a parameter.

The 22-bit word address is split into a 12-bit row and a 10-bit column, and both share one address bus. On writes, only the column strobes whose byte enable is set are pulsed. A write uses one of two timings. In the early form, write-enable is already low before any column strobe falls. In the late form, output-enable stays high for the whole cycle and write-enable drops only after the column strobe has fallen. Reads pulse both lanes and open the outputs only while a column strobe is low. The read word is captured a fixed access count after the column strobe falls and is returned with a one-clock valid pulse.

Between cycles, the row strobe and both column strobes go back high together. They stay high for a precharge count before the next cycle starts. No cycle ever begins with a column strobe still low, so stale read data cannot carry over into the next cycle.

Top module: `dram_strobe_seq`

## Requirements
- R1: Column strobe `dram_cas_n[0]` qualifies data bits 7:0 and `dram_cas_n[1]` qualifies bits 15:8. A write pulses exactly the strobes whose `req_be` bit is 1, so a byte whose enable is 0 keeps its stored value. A read pulses both strobes.
- R2: An early write (`req_late`=0) has `dram_we_n` low from the cycle in which `dram_ras_n` falls until the column strobes rise. It is therefore low before the first column strobe falls.
- R3: A late write (`req_late`=1) keeps `dram_oe_n` high for the whole cycle. `dram_we_n` is still high in the first clock that a column strobe is low and goes low in a later clock of that same strobe pulse.
- R4: Both column strobes are high whenever `dram_ras_n` falls. Once a cycle ends, `dram_ras_n` and both column strobes stay high for at least `T_RP` clocks before the next fall of `dram_ras_n`. `req_ready` is 1 only while all strobes are high.
- R5: `dram_dq_oe` is 1 only while `dram_ras_n` is low in a write cycle and is never 1 in a read cycle.
- R6: The first column strobe falls `T_RCD` clocks after `dram_ras_n` falls. Every strobe that is pulsed stays low for exactly `T_CAS` clocks.
- R7: `dram_addr` carries the row, word-address bits 21:10, when `dram_ras_n` falls and for `T_RAD` clocks. After that it carries the column, zero-extended bits 9:0, and still carries it when the column strobes fall.
- R8: In a read, `dram_oe_n` is low only while a column strobe is low. The word on `dram_dq_in` is sampled `T_CAC` clocks after the first column strobe falls. `rsp_valid` is high for exactly one clock after that sample, with the word on `rsp_rdata`.
- R9: While `rst_n` is low, and at the first sample after reset, all four strobes are high, `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 22 | Word address, row in bits 21:10, column in bits 9:0 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_late | input | 1 | Write timing select: 1 late (output-enable high), 0 early |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock pulse: read data captured |
| rsp_rdata | output | 16 | Last captured read word |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 lower lane, bit 1 upper lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Data drive enable |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The memory model in the bench latches row and column on the strobe edges and writes only the lanes whose strobe is low. Its read-backs therefore depend on address multiplexing, lane masking and capture timing all being right at once. Full-word early writes to the low, high and alternating-bit address corners check that row and column bits stay separate. Single-lane writes followed by full reads show whether a disabled byte was left alone, and whether each strobe drives its own byte. Late writes and early writes go to the same addresses and are set apart by when write-enable moves against the first column fall, and by whether output-enable ever drops. Back-to-back requests check that the precharge gap and the ready handshake hold up under steady load.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_COL  = 2'd2,
      ST_PRE  = 2'd3
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_cycle_timer.sv
module dram_cycle_timer
   import dram_seq_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_CP  = 2,
   parameter int T_RCD = 3,
   parameter int T_RAD = 1,
   parameter int T_CAS = 4,
   parameter int T_CAC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready,
   output logic ras_act,
   output logic col_sel,
   output logic cas_phase,
   output logic we_late_ok,
   output logic capture
);

   localparam int T_PRE = max2(T_RP, T_CP);
   localparam int MAXT  = max2(max2(T_RCD, T_CAS), T_PRE);
   localparam int CNT_W = $clog2(MAXT + 1);

   localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(T_CAS - 1);
   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_PRE - 1);
   localparam logic [CNT_W-1:0] CAC_LAST = CNT_W'(T_CAC - 1);
   localparam logic [CNT_W-1:0] RAD_CNT  = CNT_W'(T_RAD);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (start) state <= ST_ROW;
            end
            ST_ROW: begin
               if (cnt == RCD_LAST) begin
                  state <= ST_COL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_COL: begin
               if (cnt == CAS_LAST) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PRE: begin
               if (cnt == PRE_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign ready      = (state == ST_IDLE);
   assign ras_act    = (state == ST_ROW) || (state == ST_COL);
   assign cas_phase  = (state == ST_COL);
   assign col_sel    = cas_phase || ((state == ST_ROW) && (cnt >= RAD_CNT));
   assign we_late_ok = cas_phase && (cnt != '0);
   assign capture    = cas_phase && (cnt == CAC_LAST);

   // R6: the column phase is entered only from a full row-to-column delay
   p_rcd_before_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_phase) |-> ($past(state) == ST_ROW && $past(cnt) == RCD_LAST));

   // R4: a new row phase is entered only from the idle state
   p_row_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ROW && cnt == '0) |-> $past(state) == ST_IDLE);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ADDR_W = 22,
   parameter int ROW_W  = 12,
   parameter int COL_W  = 10
) (
   input  logic [ADDR_W-1:0] word_addr,
   input  logic              col_sel,
   output logic [ROW_W-1:0]  mem_addr
);

   localparam int PAD_W = ROW_W - COL_W;

   logic [ROW_W-1:0] row_part;
   logic [ROW_W-1:0] col_part;

   assign row_part = word_addr[ADDR_W-1 -: ROW_W];

   generate
      if (PAD_W > 0) begin : g_pad_col
         assign col_part = {{PAD_W{1'b0}}, word_addr[COL_W-1:0]};
      end else begin : g_flat_col
         assign col_part = word_addr[COL_W-1:0];
      end
   endgenerate

   assign mem_addr = col_sel ? col_part : row_part;

endmodule

// File: rtl/dram_lane_io.sv
module dram_lane_io #(
   parameter int T_CAS  = 4,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cas_phase,
   input  logic              lane_en,
   input  logic              capture,
   input  logic [LANE_W-1:0] wdata_b,
   input  logic [LANE_W-1:0] dq_in_b,
   output logic              cas_n,
   output logic [LANE_W-1:0] dq_out_b,
   output logic [LANE_W-1:0] rdata_b
);

   localparam int LW_W = $clog2(T_CAS + 1);

   logic [LANE_W-1:0] rdata_q;
   logic [LW_W-1:0]   low_cnt;

   assign cas_n    = !(cas_phase && lane_en);
   assign dq_out_b = wdata_b;
   assign rdata_b  = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture && lane_en) begin
         rdata_q <= dq_in_b;
      end
   end

   // pulse-width tracker used only by the checks below
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!cas_n) begin
         low_cnt <= low_cnt + 1'b1;
      end else begin
         low_cnt <= '0;
      end
   end

   // R6: a lane strobe never stays low longer than T_CAS clocks
   p_cas_width_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> (low_cnt < LW_W'(T_CAS)));

   // R6: a lane strobe rises only after a full T_CAS low pulse
   p_cas_width_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> ($past(low_cnt) == LW_W'(T_CAS - 1)));

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int ROW_W  = 12,
   parameter int COL_W  = 10,
   parameter int DATA_W = 16,
   parameter int T_RP   = 3,
   parameter int T_CP   = 2,
   parameter int T_RCD  = 3,
   parameter int T_RAD  = 1,
   parameter int T_CAS  = 4,
   parameter int T_CAC  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic                 req_write,
   input  logic                 req_late,
   input  logic [DATA_W/8-1:0]  req_be,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic [ROW_W-1:0]     dram_addr,
   output logic                 dram_ras_n,
   output logic [DATA_W/8-1:0]  dram_cas_n,
   output logic                 dram_we_n,
   output logic                 dram_oe_n,
   output logic [DATA_W-1:0]    dram_dq_out,
   output logic                 dram_dq_oe,
   input  logic [DATA_W-1:0]    dram_dq_in
);

   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = 8;

   // elaboration-time parameter checks
   generate
      if (ADDR_W != ROW_W + COL_W) begin : g_bad_split
         $error("ADDR_W must equal ROW_W + COL_W");
      end
      if (COL_W > ROW_W) begin : g_bad_col
         $error("COL_W must not exceed ROW_W");
      end
      if (DATA_W % 8 != 0 || LANES < 1) begin : g_bad_data
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (T_RAD < 1 || T_RAD >= T_RCD) begin : g_bad_rad
         $error("T_RAD must be in 1 .. T_RCD-1");
      end
      if (T_CAS < 2) begin : g_bad_cas
         $error("T_CAS must be at least 2 for late writes");
      end
      if (T_CAC < 1 || T_CAC > T_CAS) begin : g_bad_cac
         $error("T_CAC must be in 1 .. T_CAS");
      end
      if (T_RP < 1 || T_CP < 1) begin : g_bad_pre
         $error("precharge counts must be at least 1");
      end
   endgenerate

   logic              start;
   logic              ready;
   logic              ras_act;
   logic              col_sel;
   logic              cas_phase;
   logic              we_late_ok;
   logic              capture;
   logic              cap_rd;
   logic              cas_any;

   logic [ADDR_W-1:0] cur_addr;
   logic              cur_write;
   logic              cur_late;
   logic [LANES-1:0]  cur_be;
   logic [DATA_W-1:0] cur_wdata;
   logic [LANES-1:0]  lane_en;
   logic              rsp_valid_q;

   assign start     = req_valid && ready;
   assign req_ready = ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         cur_write <= 1'b0;
         cur_late  <= 1'b0;
         cur_be    <= '0;
         cur_wdata <= '0;
      end else if (start) begin
         cur_addr  <= req_addr;
         cur_write <= req_write;
         cur_late  <= req_late;
         cur_be    <= req_be;
         cur_wdata <= req_wdata;
      end
   end

   dram_cycle_timer #(
      .T_RP  (T_RP),
      .T_CP  (T_CP),
      .T_RCD (T_RCD),
      .T_RAD (T_RAD),
      .T_CAS (T_CAS),
      .T_CAC (T_CAC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ready      (ready),
      .ras_act    (ras_act),
      .col_sel    (col_sel),
      .cas_phase  (cas_phase),
      .we_late_ok (we_late_ok),
      .capture    (capture)
   );

   dram_addr_mux #(
      .ADDR_W (ADDR_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) u_addr (
      .word_addr (cur_addr),
      .col_sel   (col_sel),
      .mem_addr  (dram_addr)
   );

   assign lane_en = cur_write ? cur_be : {LANES{1'b1}};
   assign cap_rd  = capture && !cur_write;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         dram_lane_io #(
            .T_CAS  (T_CAS),
            .LANE_W (LANE_W)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cas_phase(cas_phase),
            .lane_en  (lane_en[gi]),
            .capture  (cap_rd),
            .wdata_b  (cur_wdata[gi*LANE_W +: LANE_W]),
            .dq_in_b  (dram_dq_in[gi*LANE_W +: LANE_W]),
            .cas_n    (dram_cas_n[gi]),
            .dq_out_b (dram_dq_out[gi*LANE_W +: LANE_W]),
            .rdata_b  (rsp_rdata[gi*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign dram_ras_n = !ras_act;
   assign dram_we_n  = !(cur_write && ras_act && (cur_late ? we_late_ok : 1'b1));
   assign dram_oe_n  = !(!cur_write && cas_phase);
   assign dram_dq_oe = cur_write && ras_act;

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_valid_q <= 1'b0;
      else        rsp_valid_q <= cap_rd;
   end
   assign rsp_valid = rsp_valid_q;

   assign cas_any = (dram_cas_n != {LANES{1'b1}});

   // R4: no cycle opens with a column strobe already low
   p_cas_high_at_ras_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> !cas_any);

   // R4: requests are taken only with every strobe precharged
   p_ready_precharged_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (dram_ras_n && !cas_any));

   // R5: data is driven only inside a write cycle
   p_drive_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_ras_n && cur_write));

   // R2: early write has write-enable low before the first column fall
   p_early_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_any) && cur_write && !cur_late) |-> (!dram_we_n && $past(!dram_we_n)));

   // R3: late write keeps write-enable high at the column fall
   p_late_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_any) && cur_write && cur_late) |-> dram_we_n);

   // R3: outputs stay closed for the whole write
   p_write_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras_n && cur_write) |-> dram_oe_n);

   // R8: outputs open only under a low column strobe in a read
   p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (cas_any && !cur_write));

   // R8: read response is a single-clock pulse
   p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7: row bits are on the bus when the row strobe falls
   p_row_at_ras_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (dram_addr == cur_addr[ADDR_W-1 -: ROW_W]));

endmodule

// File: tb/dram_strobe_seq_bench.sv
module dram_strobe_seq_bench;

   localparam int T_RP  = 3;
   localparam int T_CP  = 2;
   localparam int T_RCD = 3;
   localparam int T_RAD = 1;
   localparam int T_CAS = 4;
   localparam int T_CAC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [21:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_late = 1'b0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [11:0] dram_addr;
   logic        dram_ras_n;
   logic [1:0]  dram_cas_n;
   logic        dram_we_n;
   logic        dram_oe_n;
   logic [15:0] dram_dq_out;
   logic        dram_dq_oe;
   logic [15:0] dram_dq_in = 16'hDEAD;

   always #5 clk = ~clk;

   dram_strobe_seq #(
      .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD),
      .T_RAD(T_RAD), .T_CAS(T_CAS), .T_CAC(T_CAC)
   ) u_dram_strobe_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_late(req_late), .req_be(req_be),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   typedef struct packed {
      logic [11:0] row;
      logic [9:0]  col;
      logic        wr;
      logic        late;
      logic [1:0]  mask;
   } cyc_t;

   cyc_t        cyc_q[$];
   logic [15:0] rd_q[$];
   logic [15:0] shadow[int];
   logic [15:0] mdl[int];

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [11:0] m_row = '0;
   logic [9:0]  m_col = '0;
   logic        m_prev_ras = 1'b1;
   logic [1:0]  m_prev_cas = 2'b11;

   always @(negedge clk) begin
      if (m_prev_ras && !dram_ras_n) m_row = dram_addr;
      if (!dram_ras_n && m_prev_cas == 2'b11 && dram_cas_n != 2'b11)
         m_col = dram_addr[9:0];
      if (!dram_ras_n && !dram_we_n && dram_dq_oe) begin
         logic [15:0] w;
         int key;
         key = int'({m_row, m_col});
         w = mdl.exists(key) ? mdl[key] : 16'h0000;
         if (!dram_cas_n[0]) w[7:0]  = dram_dq_out[7:0];
         if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
         mdl[key] = w;
      end
      if (!dram_ras_n && !dram_oe_n && dram_cas_n != 2'b11) begin
         int key;
         key = int'({m_row, m_col});
         dram_dq_in = mdl.exists(key) ? mdl[key] : 16'h0000;
      end else begin
         dram_dq_in = 16'hDEAD;
      end
      m_prev_ras = dram_ras_n;
      m_prev_cas = dram_cas_n;
   end

   // ---------------- monitor ----------------
   logic       p_ras = 1'b1;
   logic [1:0] p_cas = 2'b11;
   logic       p_rsp = 1'b0;
   logic [1:0] mask_seen;
   int         cas_cnt0, cas_cnt1;
   int         ras_hi_cnt = 0;
   int         since_ras;
   int         k_cas = 0;
   bit         seen_cycle = 0;
   bit         we_at_cas, we_low_seen, oe_low_seen;
   cyc_t       cur;

   always @(negedge clk) begin
      if (rst_n) begin
         if (k_cas > 0) k_cas++;
         if (p_ras && !dram_ras_n) begin
            chk(dram_cas_n == 2'b11, "R4 cas high at ras fall", dram_cas_n, 2'b11);
            if (seen_cycle)
               chk(ras_hi_cnt >= T_RP, "R4 precharge gap", ras_hi_cnt, T_RP);
            seen_cycle = 1;
            if (cyc_q.size() == 0) begin
               chk(0, "R4 unexpected cycle", 0, 1);
               cur = '0;
            end else begin
               cur = cyc_q[0];
            end
            chk(dram_addr == cur.row, "R7 row address", dram_addr, cur.row);
            mask_seen = 2'b00; cas_cnt0 = 0; cas_cnt1 = 0; since_ras = 0;
            we_at_cas = 1'b1; we_low_seen = 0; oe_low_seen = 0; k_cas = 0;
         end
         if (!dram_ras_n) begin
            since_ras++;
            if (p_cas == 2'b11 && dram_cas_n != 2'b11) begin
               chk(dram_addr == {2'b00, cur.col}, "R7 column address", dram_addr,
                   {2'b00, cur.col});
               chk(since_ras == T_RCD + 1, "R6 ras-to-cas delay", since_ras - 1, T_RCD);
               we_at_cas = dram_we_n;
               k_cas = 1;
            end
            mask_seen |= ~dram_cas_n;
            if (!dram_cas_n[0]) cas_cnt0++;
            if (!dram_cas_n[1]) cas_cnt1++;
            if (!dram_we_n) we_low_seen = 1;
            if (!dram_oe_n) oe_low_seen = 1;
            if (dram_dq_oe && !cur.wr) chk(0, "R5 drive in read", 1, 0);
            if (!dram_oe_n && dram_cas_n == 2'b11) chk(0, "R8 oe without cas", 1, 0);
            if (req_ready) chk(0, "R4 ready while busy", 1, 0);
            ras_hi_cnt = 0;
         end else begin
            ras_hi_cnt++;
            if (dram_dq_oe) chk(0, "R5 drive with ras high", 1, 0);
         end
         if (!p_ras && dram_ras_n) begin
            if (cyc_q.size() != 0) void'(cyc_q.pop_front());
            chk(mask_seen == cur.mask, "R1 lane strobes", mask_seen, cur.mask);
            if (cur.mask[0]) chk(cas_cnt0 == T_CAS, "R6 lower cas width", cas_cnt0, T_CAS);
            if (cur.mask[1]) chk(cas_cnt1 == T_CAS, "R6 upper cas width", cas_cnt1, T_CAS);
            if (cur.wr && !cur.late) begin
               chk(we_at_cas == 1'b0, "R2 we low before cas", we_at_cas, 0);
               chk(!oe_low_seen, "R2 oe high in early write", oe_low_seen, 0);
            end else if (cur.wr) begin
               chk(we_at_cas == 1'b1 && we_low_seen, "R3 we after cas",
                   {we_at_cas, we_low_seen}, 2'b11);
               chk(!oe_low_seen, "R3 oe high in late write", oe_low_seen, 0);
            end else begin
               chk(!we_low_seen && oe_low_seen, "R8 read strobes",
                   {we_low_seen, oe_low_seen}, 2'b01);
            end
         end
         if (rsp_valid) begin
            chk(k_cas == T_CAC + 1, "R8 capture timing", k_cas - 1, T_CAC);
            chk(!p_rsp, "R8 single pulse", p_rsp, 0);
            if (rd_q.size() == 0) begin
               chk(0, "R8 unexpected response", 0, 1);
            end else begin
               logic [15:0] e;
               e = rd_q.pop_front();
               chk(rsp_rdata == e, "R8 R1 read data", rsp_rdata, e);
            end
         end
      end
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      p_rsp = rsp_valid;
   end

   // ---------------- driver ----------------
   task automatic do_req(input logic [21:0] a, input bit wr, input bit late,
                         input logic [1:0] be, input logic [15:0] d);
      cyc_t c;
      int   key;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_late = late;
      req_be = be; req_wdata = d;
      c.row = a[21:10]; c.col = a[9:0]; c.wr = wr; c.late = late;
      c.mask = wr ? be : 2'b11;
      cyc_q.push_back(c);
      key = int'(a);
      if (wr) begin
         logic [15:0] w;
         w = shadow.exists(key) ? shadow[key] : 16'h0000;
         if (be[0]) w[7:0]  = d[7:0];
         if (be[1]) w[15:8] = d[15:8];
         shadow[key] = w;
      end else begin
         rd_q.push_back(shadow.exists(key) ? shadow[key] : 16'h0000);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n,
          "R9 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
      chk(!dram_dq_oe && !rsp_valid, "R9 outputs in reset", {dram_dq_oe, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R9 ready after reset", req_ready, 1);
      chk(dram_ras_n && dram_cas_n == 2'b11, "R9 strobes after reset",
          {dram_ras_n, dram_cas_n}, 3'h7);

      // early full writes at address corners (R2, R7)
      do_req(22'h000000, 1, 0, 2'b11, 16'h1234);
      do_req(22'h3FFFFF, 1, 0, 2'b11, 16'hA5C3);
      do_req(22'h155AAA, 1, 0, 2'b11, 16'h0FF0);
      do_req(22'h2AA155, 1, 0, 2'b11, 16'hBEEF);
      do_req(22'h000000, 0, 0, 2'b11, 16'h0);
      do_req(22'h3FFFFF, 0, 0, 2'b11, 16'h0);
      do_req(22'h155AAA, 0, 0, 2'b11, 16'h0);
      do_req(22'h2AA155, 0, 0, 2'b11, 16'h0);
      // single-lane early writes (R1)
      do_req(22'h155AAA, 1, 0, 2'b01, 16'h7711);
      do_req(22'h155AAA, 0, 0, 2'b11, 16'h0);
      do_req(22'h2AA155, 1, 0, 2'b10, 16'h4466);
      do_req(22'h2AA155, 0, 0, 2'b11, 16'h0);
      // late writes, full and per lane (R3, R1)
      do_req(22'h000401, 1, 1, 2'b11, 16'hC0DE);
      do_req(22'h000401, 0, 0, 2'b11, 16'h0);
      do_req(22'h000401, 1, 1, 2'b10, 16'h99AA);
      do_req(22'h000401, 0, 0, 2'b11, 16'h0);
      do_req(22'h3FFFFF, 1, 1, 2'b01, 16'h33CC);
      do_req(22'h3FFFFF, 0, 0, 2'b11, 16'h0);
      // back-to-back mixed traffic (R4, R8)
      for (int i = 0; i < 6; i++) begin
         do_req(22'(i * 22'h041021), 1, (i % 2) == 1, 2'b11, 16'(16'h1111 * (i + 1)));
         do_req(22'(i * 22'h041021), 0, 0, 2'b11, 16'h0);
      end
      repeat (20) @(negedge clk);
      chk(cyc_q.size() == 0, "R4 all cycles issued", cyc_q.size(), 0);
      chk(rd_q.size() == 0, "R8 all reads answered", rd_q.size(), 0);
      summary();
      $finish;
   end

endmodule